// File: doc/BRIEF.md
# FIFO Status Interrupt Controller

This block turns the fill levels and push/pop strobes of a serial controller's transmit and receive FIFOs (63 words each) into six status conditions. It latches them into a sticky status register and drives one interrupt line from the conditions that software has enabled. Two watermark registers set the point at which the transmit "running low" and receive "data available" conditions fire.

Software controls the enable mask through two write-only ports. Writing ones to the set port enables those bits, and writing ones to the clear port disables them. A separate read-only port returns the current mask. To acknowledge an interrupt, software reads the status register and writes the same value back; each 1 written clears that bit. Writes use a one-cycle strobe with an address and data. Reads are combinational from the read address.

Register addresses: 0 status (read, write-1-to-clear), 1 enable-set (write only), 2 enable-clear (write only), 3 mask (read only), 4 TX watermark, 5 RX watermark. All other addresses read zero.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is low, status and mask read 0, the TX watermark reads 1, the RX watermark reads 32 and `irq` is 0.
- R2: Status bit 2 is set one clock after `txLevel` is below the TX watermark. With the watermark at 1, this happens only when the TX FIFO is empty.
- R3: Status bit 3 is set one clock after `txLevel` equals 63. Status bit 5 is set one clock after `rxLevel` equals 63.
- R4: Status bit 4 is set one clock after `rxLevel` is at or above the RX watermark.
- R5: Status bit 0 is set when `rxPush` is high while `rxLevel` is 63. Status bit 6 is set when `txPop` is high while `txLevel` is 0. A push or pop at any other level sets nothing.
- R6: A status bit stays set after its cause goes away, until it is acknowledged.
- R7: Writing to address 0 clears, on that clock, every status bit written as 1 and leaves bits written as 0 unchanged. A level condition that is still true sets its bit again on the following clock.
- R8: Writing 1s to address 1 sets those mask bits, and writing 1s to address 2 clears them. Bits written as 0 keep their value, and address 3 returns the mask.
- R9: `irq` is high exactly when some status bit and the matching mask bit are both set. It follows a status or mask change in the same cycle that the register changes.
- R10: Bit 1 and bits 7 to 31 of status and mask always read 0. Addresses 1, 2, 6 and 7 read 0.
- R11: Writing to address 4 or 5 loads the low 6 data bits into the TX or RX watermark. The value reads back, and the condition compares against it from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| txLevel | input | 6 | TX FIFO entry count |
| rxLevel | input | 6 | RX FIFO entry count |
| rxPush | input | 1 | RX FIFO write attempt |
| txPop | input | 1 | TX FIFO read attempt |
| irq | output | 1 | Interrupt request |

## Verification
A FIFO level or strobe applied before a clock edge shows up in the status register after that edge, one cycle later. A register write lands on its own edge. `irq` and `rdData` change combinationally from those registers, so they settle in the same cycle as the register they depend on. The stimulus changes inputs on the falling edge, and each expected value is queued together with the address it reads. The compare runs one nanosecond later, before the next rising edge, so every expected value reflects exactly the rising edges that have already occurred. Where a check itself spans an edge, as in the re-set after an acknowledge, the expected value is the one left after that edge.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
package ifcPkg;
  parameter int NBITS  = 7;
  parameter int ADDR_W = 3;

  // status / mask bit positions (software decodes these)
  localparam int B_RXOVF   = 0;
  localparam int B_TXLOW   = 2;
  localparam int B_TXFULL  = 3;
  localparam int B_RXAVAIL = 4;
  localparam int B_RXFULL  = 5;
  localparam int B_TXUNDER = 6;
  localparam logic [NBITS-1:0] BIT_VALID = 7'b111_1101;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENSET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXWM   = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXWM   = 3'd5;

  typedef struct packed {
    logic [NBITS-1:0] ack;
    logic [NBITS-1:0] maskSet;
    logic [NBITS-1:0] maskClr;
    logic             txWmWr;
    logic             rxWmWr;
  } strobe_t;
endpackage

// File: rtl/ifc_ctrl.sv
`timescale 1ns/1ps
module ifcCtrl
  import ifcPkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NBITS-1:0]  wrBits,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (wrAddr)
        A_STATUS: stb.ack     = wrBits & BIT_VALID;
        A_ENSET:  stb.maskSet = wrBits & BIT_VALID;
        A_ENCLR:  stb.maskClr = wrBits & BIT_VALID;
        A_TXWM:   stb.txWmWr  = 1'b1;
        A_RXWM:   stb.rxWmWr  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ifc_datapath.sv
`timescale 1ns/1ps
module ifcDatapath
  import ifcPkg::*;
#(
  parameter int DEPTH    = 63,
  parameter int DATA_W   = 32,
  parameter int LVL_W    = 6,
  parameter int TXWM_RST = 1,
  parameter int RXWM_RST = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [LVL_W-1:0]  wmVal,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              rxPush,
  input  logic              txPop,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [NBITS-1:0] cond;
  logic [NBITS-1:0] statusQ;
  logic [NBITS-1:0] maskQ;
  logic [LVL_W-1:0] txWmQ, rxWmQ;

  always_comb begin
    cond            = '0;
    cond[B_RXOVF]   = rxPush && (rxLevel == FULL_LVL);
    cond[B_TXLOW]   = txLevel < txWmQ;
    cond[B_TXFULL]  = txLevel == FULL_LVL;
    cond[B_RXAVAIL] = rxLevel >= rxWmQ;
    cond[B_RXFULL]  = rxLevel == FULL_LVL;
    cond[B_TXUNDER] = txPop && (txLevel == '0);
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (BIT_VALID[i]) begin : g_live
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= (bitQ | cond[i]) & ~stb.ack[i];
      end
      assign statusQ[i] = bitQ;
    end else begin : g_hole
      assign statusQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      txWmQ <= LVL_W'(TXWM_RST);
      rxWmQ <= LVL_W'(RXWM_RST);
    end else begin
      maskQ <= (maskQ | stb.maskSet) & ~stb.maskClr;
      if (stb.txWmWr) txWmQ <= wmVal;
      if (stb.rxWmWr) rxWmQ <= wmVal;
    end
  end

  assign irq = |(statusQ & maskQ);

  always_comb begin
    case (rdAddr)
      A_STATUS: rdData = DATA_W'(statusQ);
      A_MASK:   rdData = DATA_W'(maskQ);
      A_TXWM:   rdData = DATA_W'(txWmQ);
      A_RXWM:   rdData = DATA_W'(rxWmQ);
      default:  rdData = '0;
    endcase
  end

  assert_txlow_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel < txWmQ && !stb.ack[B_TXLOW]) |=> statusQ[B_TXLOW]);

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[B_TXUNDER] && !stb.ack[B_TXUNDER]) |=> statusQ[B_TXUNDER]);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack[B_RXOVF] && !(rxPush && rxLevel == FULL_LVL)) |=> !statusQ[B_RXOVF]);

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.maskSet) |=> ((maskQ & $past(stb.maskSet)) == $past(stb.maskSet)));

  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.maskClr) |=> ((maskQ & $past(stb.maskClr)) == '0));
endmodule

// File: rtl/fifo_irq_ctrl.sv
`timescale 1ns/1ps
module fifo_irq_ctrl
  import ifcPkg::*;
#(
  parameter int DEPTH    = 63,
  parameter int DATA_W   = 32,
  parameter int TXWM_RST = 1,
  parameter int RXWM_RST = 32,
  localparam int LVL_W   = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              rxPush,
  input  logic              txPop,
  output logic              irq
);
  strobe_t stb;

  ifcCtrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrBits (wrData[NBITS-1:0]),
    .stb    (stb)
  );

  ifcDatapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .TXWM_RST(TXWM_RST), .RXWM_RST(RXWM_RST)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wmVal   (wrData[LVL_W-1:0]),
    .txLevel (txLevel),
    .rxLevel (rxLevel),
    .rxPush  (rxPush),
    .txPop   (txPop),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .irq     (irq)
  );
endmodule

// File: tb/sim_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [5:0]  txLevel = 6'd5;
  logic [5:0]  rxLevel = 6'd0;
  logic        rxPush = 1'b0;
  logic        txPop = 1'b0;
  logic        irq;

  int nChecked = 0;
  int nFailed  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxPush(rxPush), .txPop(txPop), .irq(irq)
  );

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic expectRd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rdAddr = a;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic expectIrq(input logic e, input string tag);
    item_t it;
    it.isIrq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      act = it.isIrq ? {31'b0, irq} : rdData;
      nChecked++;
      if (act !== it.exp) begin
        nFailed++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    expectRd(3'd0, 32'h0, "R1 status");
    expectRd(3'd3, 32'h0, "R1 mask");
    expectRd(3'd4, 32'd1, "R1 txWm");
    expectRd(3'd5, 32'd32, "R1 rxWm");
    expectIrq(1'b0, "R1 irq");
    rstN = 1'b1;
    step();
    expectRd(3'd0, 32'h0, "R2 level above watermark");
    txLevel = 6'd0; step();
    expectRd(3'd0, 32'h4, "R2 tx empty");
    txLevel = 6'd5; step();
    expectRd(3'd0, 32'h4, "R6 sticky level");
    expectIrq(1'b0, "R9 masked");
    wr(3'd1, 32'h4);
    expectRd(3'd3, 32'h4, "R8 enable set");
    expectIrq(1'b1, "R9 enabled");
    wr(3'd2, 32'h4);
    expectRd(3'd3, 32'h0, "R8 enable clear");
    expectIrq(1'b0, "R9 disabled");
    wr(3'd0, 32'h4);
    expectRd(3'd0, 32'h0, "R7 ack");
    txLevel = 6'd0; step();
    wr(3'd0, 32'h4);
    expectRd(3'd0, 32'h0, "R7 cleared in write cycle");
    expectRd(3'd0, 32'h4, "R7 level re-sets");
    txLevel = 6'd5; wr(3'd0, 32'h4);
    expectRd(3'd0, 32'h0, "R7 ack after level gone");
    // R11 watermarks
    wr(3'd4, 32'd10);
    expectRd(3'd4, 32'd10, "R11 txWm readback");
    expectRd(3'd0, 32'h4, "R11 new txWm compares");
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h4);
    expectRd(3'd0, 32'h0, "R11 restored txWm");
    // R3 full conditions
    txLevel = 6'd63; step();
    expectRd(3'd0, 32'h8, "R3 tx full");
    txLevel = 6'd5; wr(3'd0, 32'h8);
    expectRd(3'd0, 32'h0, "R3 tx full acked");
    rxLevel = 6'd63; step();
    expectRd(3'd0, 32'h30, "R3 rx full and R4 avail");
    rxLevel = 6'd0; wr(3'd0, 32'hFFFF_FFFF);
    expectRd(3'd0, 32'h0, "R7 ack all");
    // R4 rx watermark
    wr(3'd5, 32'd3);
    expectRd(3'd5, 32'd3, "R11 rxWm readback");
    rxLevel = 6'd2; step();
    expectRd(3'd0, 32'h0, "R4 below rx watermark");
    rxLevel = 6'd3; step();
    expectRd(3'd0, 32'h10, "R4 at rx watermark");
    rxLevel = 6'd0; wr(3'd0, 32'h10);
    expectRd(3'd0, 32'h0, "R4 acked");
    // R5 events
    rxLevel = 6'd63; rxPush = 1'b1; step();
    rxPush = 1'b0; rxLevel = 6'd0;
    expectRd(3'd0, 32'h31, "R5 rx overflow");
    wr(3'd0, 32'h30);
    expectRd(3'd0, 32'h1, "R6 overflow sticky");
    wr(3'd0, 32'h1);
    expectRd(3'd0, 32'h0, "R7 overflow acked");
    rxLevel = 6'd2; rxPush = 1'b1; step();
    rxPush = 1'b0;
    expectRd(3'd0, 32'h0, "R5 push not full");
    txLevel = 6'd0; txPop = 1'b1; step();
    txPop = 1'b0; txLevel = 6'd5;
    expectRd(3'd0, 32'h44, "R5 tx underflow");
    // R9 interrupt
    wr(3'd1, 32'h40);
    expectIrq(1'b1, "R9 underflow enabled");
    wr(3'd0, 32'h4);
    expectIrq(1'b1, "R9 unmasked bit ack keeps irq");
    wr(3'd0, 32'h40);
    expectIrq(1'b0, "R9 irq drops on ack");
    expectRd(3'd0, 32'h0, "R7 all clear");
    // R10 reserved
    wr(3'd1, 32'hFFFF_FFFF);
    expectRd(3'd3, 32'h7D, "R10 mask reserved bits");
    expectRd(3'd1, 32'h0, "R10 enable-set reads zero");
    expectRd(3'd2, 32'h0, "R10 enable-clear reads zero");
    expectRd(3'd6, 32'h0, "R10 unused address");
    wr(3'd2, 32'hFFFF_FFFF);
    expectRd(3'd3, 32'h0, "R8 clear all");
    wait (sb.size() == 0);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  end
endmodule